// File: doc/BRIEF.md
# Paged Branch and Return Sequencer

This block owns the 16-bit byte address and the bit position of a serial instruction stream for a speech microsequencer. An instruction decoder upstream consumes the stream one bit at a time. It pulses an advance strobe for each bit it takes. When it recognises a control-flow instruction, it raises a branch request. Each request carries a kind code and a 12-bit field. For a jump, that field is the branch offset. For a return or page change, its low nibble is the 4-bit immediate.

The upper nibble of every jump target comes from a 4-bit page register. That register resets to 1 and is changed only by a page-change request with a nonzero immediate. The same request kind with a zero immediate is a return. A return pops the single return-stack entry. It then clears the top nibble of the stored entry, so a second return finds page 0. A popped page of 0 stops the sequencer. It stays halted until a start address arrives on the external load port.

External loads always land in page 1 and leave the page register alone. An external load that arrives while the sequencer is running is held as pending. That pending address is used the moment a return would otherwise halt.

Top module: `spk_branch_seq`

## Requirements
- R1: After reset the sequencer is halted, the address is 0, the bit position is 0 and the page register holds 1.
- R2: While running, each advance strobe raises the bit position by one. A strobe at bit position 7 moves the address up by one and sets the bit position to 0.
- R3: While halted, advance strobes and branch requests of every kind have no effect on the address, the bit position or the stored state.
- R4: An external load while halted sets the address to page 1 followed by the 12-bit load value, with bit position 0. The sequencer runs again from the next cycle.
- R5: An external load while running leaves the address unchanged and is held as pending. A later pending load replaces an earlier one.
- R6: A jump request (kind 00) sets the address to the page register followed by the 12-bit offset, with bit position 0.
- R7: A return-or-page request (kind 10) with a nonzero immediate in offset bits 3:0 loads that value into the page register. The value is kept until the next such request. External loads never change the page register.
- R8: A subroutine request (kind 01) jumps like R6. It also stores the return address in the single stack entry, replacing the old entry. The return address is the current address when the bit position is 0, and the next byte address otherwise.
- R9: A kind 10 request with a zero immediate is a return. When the stored entry's top nibble is nonzero, the address becomes that entry with bit position 0. The stored entry then keeps its low 12 bits and gets a top nibble of 0.
- R10: A return whose popped top nibble is 0 halts the sequencer when no external load is pending or arriving. Otherwise it goes straight to the external address and stays running.
- R11: Request kind 11 does nothing. A branch request takes priority over an advance strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Bit-advance strobe |
| br_valid | input | 1 | Branch request valid |
| br_kind | input | 2 | 00 jump, 01 subroutine jump, 10 return or page change, 11 none |
| br_target | input | 12 | Branch offset; bits 3:0 are the immediate for kind 10 |
| ext_valid | input | 1 | External start-address load |
| ext_addr | input | 12 | External start offset (page forced to 1) |
| addr | output | 16 | Current byte address |
| bit_pos | output | 3 | Bit position within the byte |
| halted | output | 1 | Sequencer halted |

## Verification
The bench targets the return poisoning. A design that did not clear the stored top nibble would return to the same place twice and never halt. It then checks that a page-0 return with an external load pending jumps straight to page 1. A design that ignored the pending load would sit halted. Subroutine jumps are issued at mid-byte and on a byte boundary. This catches a design that stores an unaligned or off-by-one return address. Jumps made after an external load must still use the programmed page. A design that let the load write the page register would land in page 1.

// File: rtl/spk_branch_seq.sv
module spk_branch_seq #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int BIT_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic                       br_valid,
  input  logic [1:0]                 br_kind,
  input  logic [ADDR_W-PAGE_W-1:0]   br_target,
  input  logic                       ext_valid,
  input  logic [ADDR_W-PAGE_W-1:0]   ext_addr,
  output logic [ADDR_W-1:0]          addr,
  output logic [BIT_W-1:0]           bit_pos,
  output logic                       halted
);
  localparam int OFS_W = ADDR_W - PAGE_W;
  localparam logic [1:0] K_JMP = 2'b00;
  localparam logic [1:0] K_JSR = 2'b01;
  localparam logic [1:0] K_RET = 2'b10;
  localparam logic [BIT_W-1:0] BIT_LAST = {BIT_W{1'b1}};

  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] stk, pend_a;
  logic              pend_v;

  wire [ADDR_W-1:0] ext_full = {PAGE_W'(1), ext_addr};
  wire [ADDR_W-1:0] ext_tgt  = ext_valid ? ext_full : pend_a;
  wire              have_ext = ext_valid | pend_v;
  wire [ADDR_W-1:0] ret_addr = addr + ADDR_W'(bit_pos != '0);
  wire [ADDR_W-1:0] jmp_addr = {page, br_target};
  wire              pop_dead = (stk[ADDR_W-1 -: PAGE_W] == '0);
  wire [PAGE_W-1:0] imm      = br_target[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      bit_pos <= '0;
      halted  <= 1'b1;
      page    <= PAGE_W'(1);
      stk     <= '0;
      pend_a  <= '0;
      pend_v  <= 1'b0;
    end else if (halted) begin
      if (ext_valid) begin
        addr    <= ext_full;
        bit_pos <= '0;
        halted  <= 1'b0;
      end
    end else begin
      if (ext_valid) begin
        pend_v <= 1'b1;
        pend_a <= ext_full;
      end
      if (br_valid) begin
        case (br_kind)
          K_JMP: begin
            addr    <= jmp_addr;
            bit_pos <= '0;
          end
          K_JSR: begin
            stk     <= ret_addr;
            addr    <= jmp_addr;
            bit_pos <= '0;
          end
          K_RET: begin
            if (imm != '0) begin
              page <= imm;
            end else begin
              stk <= {{PAGE_W{1'b0}}, stk[OFS_W-1:0]};
              if (!pop_dead) begin
                addr    <= stk;
                bit_pos <= '0;
              end else if (have_ext) begin
                addr    <= ext_tgt;
                bit_pos <= '0;
                pend_v  <= 1'b0;
              end else begin
                halted  <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end else if (adv) begin
        if (bit_pos == BIT_LAST) begin
          addr    <= addr + 1'b1;
          bit_pos <= '0;
        end else begin
          bit_pos <= bit_pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spk_branch_seq_chk.sv
module spk_branch_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int BIT_W  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     adv,
  input logic                     br_valid,
  input logic [1:0]               br_kind,
  input logic [ADDR_W-PAGE_W-1:0] br_target,
  input logic                     ext_valid,
  input logic [ADDR_W-PAGE_W-1:0] ext_addr,
  input logic [ADDR_W-1:0]        addr,
  input logic [BIT_W-1:0]         bit_pos,
  input logic                     halted
);
  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ext_valid) |=> ($stable(addr) && $stable(bit_pos) && halted));

  // R4
  ext_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && ext_valid) |=> (!halted && addr == {PAGE_W'(1), $past(ext_addr)} && bit_pos == '0));

  // R6
  jump_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_valid && br_kind == 2'b00) |=>
      (addr[ADDR_W-PAGE_W-1:0] == $past(br_target) && bit_pos == '0));

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !br_valid && adv && bit_pos != '1) |=>
      (bit_pos == $past(bit_pos) + 1'b1 && $stable(addr)));

  // R11
  nop_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_valid && br_kind == 2'b11) |=> ($stable(addr) && $stable(bit_pos) && !halted));
endmodule

bind spk_branch_seq spk_branch_seq_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BIT_W(BIT_W)
) u_chk (.*);

// File: tb/test_spk_branch_seq.sv
module test_spk_branch_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv = 1'b0, br_valid = 1'b0, ext_valid = 1'b0;
  logic [1:0] br_kind = 2'b11;
  logic [11:0] br_target = '0, ext_addr = '0;
  logic [15:0] addr;
  logic [2:0] bit_pos;
  logic halted;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  spk_branch_seq i_spk_branch_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    adv = 0; br_valid = 0; ext_valid = 0; br_kind = 2'b11;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic br(input logic [1:0] k, input logic [11:0] t);
    br_valid = 1; br_kind = k; br_target = t;
    step();
  endtask

  task automatic ext(input logic [11:0] a);
    ext_valid = 1; ext_addr = a;
    step();
  endtask

  task automatic advn(input int n);
    for (int i = 0; i < n; i++) begin
      adv = 1;
      step();
    end
  endtask

  task automatic t_reset();
    chk("R1 halted", halted, 1);
    chk("R1 addr", addr, 0);
    chk("R1 bit", bit_pos, 0);
  endtask

  task automatic t_start_and_step();
    ext(12'h234);
    chk("R4 addr", addr, 16'h1234);
    chk("R4 run", halted, 0);
    advn(3);
    chk("R2 bit", bit_pos, 3);
    chk("R2 addr held", addr, 16'h1234);
    advn(5);
    chk("R2 carry addr", addr, 16'h1235);
    chk("R2 carry bit", bit_pos, 0);
    br(2'b00, 12'hABC);
    chk("R1 page one jump", addr, 16'h1ABC);
  endtask

  task automatic t_page_and_sub();
    br(2'b10, 12'h005);
    chk("R7 setpage addr held", addr, 16'h1ABC);
    br(2'b00, 12'h010);
    chk("R7 page used", addr, 16'h5010);
    advn(3);
    br(2'b01, 12'h200);
    chk("R8 jsr target", addr, 16'h5200);
    advn(8);
    chk("R2 byte step", addr, 16'h5201);
    br(2'b01, 12'h300);
    chk("R8 jsr aligned", addr, 16'h5300);
    br(2'b10, 12'h000);
    chk("R8 R9 return overwritten entry", addr, 16'h5201);
    chk("R9 bit", bit_pos, 0);
    br(2'b10, 12'h000);
    chk("R10 poisoned pop halts", halted, 1);
    chk("R10 addr held", addr, 16'h5201);
  endtask

  task automatic t_halted_ignore();
    advn(2);
    chk("R3 adv ignored", bit_pos, 0);
    br(2'b00, 12'h777);
    chk("R3 jump ignored", addr, 16'h5201);
    br(2'b10, 12'h009);
    chk("R3 still halted", halted, 1);
    ext(12'h777);
    chk("R4 R11 page one", addr, 16'h1777);
    br(2'b00, 12'h001);
    chk("R7 page kept after ext", addr, 16'h5001);
  endtask

  task automatic t_pending();
    ext(12'h0AA);
    chk("R5 running ext no effect", addr, 16'h5001);
    ext(12'h0BB);
    br(2'b01, 12'h400);
    chk("R8 jsr", addr, 16'h5400);
    br(2'b10, 12'h000);
    chk("R9 return", addr, 16'h5001);
    br(2'b10, 12'h000);
    chk("R10 pending taken", addr, 16'h10BB);
    chk("R10 not halted", halted, 0);
    br(2'b10, 12'h000);
    chk("R10 pending consumed halts", halted, 1);
  endtask

  task automatic t_priority();
    ext(12'h050);
    advn(2);
    br(2'b11, 12'h123);
    chk("R11 kind11 addr", addr, 16'h1050);
    chk("R11 kind11 bit", bit_pos, 2);
    adv = 1;
    br(2'b00, 12'h0F0);
    chk("R11 branch over adv addr", addr, 16'h50F0);
    chk("R11 branch over adv bit", bit_pos, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_start_and_step();
    t_page_and_sub();
    t_halted_ignore();
    t_pending();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule